// File: doc/BRIEF.md
# Threshold FIFO with Flush Hold

This block is a small first-in first-out buffer for the byte path of a serial bus controller. It can sit on either the outgoing or the incoming side. It holds up to sixteen entries and presents the oldest entry at its output at all times. It reports its fill count and a set of occupancy flags. It also compares the fill count against a programmable watermark, and gives one flag suited to an incoming path and one suited to an outgoing path.

Illegal traffic does not stall the block. A write into a full buffer is thrown away, and a read from an empty buffer changes nothing. Each case raises a one-cycle error pulse on the following cycle. A flush input clears the contents at the next clock edge. It keeps the buffer empty, and ignores all traffic, for as long as it stays high.

Top module: `thr_fifo`

## Requirements
- R1: `level_o` equals the number of stored entries (0 to DEPTH, default 16, 5 bits wide) and is 0 after reset.
- R2: `pop_data_o` shows the oldest stored entry whenever `level_o` is non-zero, and each accepted pop exposes the next older entry on the following cycle.
- R3: A push while `level_o` equals DEPTH stores nothing and sets `ovf_o` for exactly the one cycle after that edge. A pop in the same cycle still removes an entry.
- R4: A pop while `level_o` is 0 leaves the buffer unchanged and sets `unf_o` for exactly the one cycle after that edge.
- R5: `full_o` is 1 only when level equals DEPTH, `empty_o` is 1 only when level is 0, `not_full_o` is the inverse of `full_o`, and `not_empty_o` is the inverse of `empty_o`.
- R6: `rx_thr_o` is 1 exactly when level is greater than or equal to the effective watermark plus one.
- R7: `tx_thr_o` is 1 exactly when level is less than or equal to the effective watermark.
- R8: The 8-bit `thr_i` is used as is from 0 to 15. Any value above 15 acts as 15, so the effective watermark is always 4 bits.
- R9: While `flush_i` is 1, each edge leaves level 0, pushes and pops are ignored, and neither error pulse is raised.
- R10: A push and a pop in the same cycle, with the level neither 0 nor DEPTH, leave the level unchanged, append the pushed byte and remove the oldest.
- R11: A push and a pop in the same cycle at level 0 store the pushed byte (level becomes 1) and raise `unf_o` for the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Write request |
| push_data_i | input | 8 | Byte to write |
| pop_i | input | 1 | Read request |
| pop_data_o | output | 8 | Oldest stored byte |
| flush_i | input | 1 | Clear and hold empty |
| thr_i | input | 8 | Watermark, clamped to 15 |
| level_o | output | 5 | Stored entry count |
| rx_thr_o | output | 1 | Level at or above watermark plus one |
| tx_thr_o | output | 1 | Level at or below watermark |
| full_o | output | 1 | Buffer full |
| not_empty_o | output | 1 | At least one entry |
| empty_o | output | 1 | No entries |
| not_full_o | output | 1 | Room for one more entry |
| ovf_o | output | 1 | Dropped-write pulse |
| unf_o | output | 1 | Empty-read pulse |

## Verification
The hardest case to reach is a write into a completely full buffer while a read is requested in the same cycle. It needs sixteen accepted writes first, and then it must show both that the read went through and that the write was lost. The stimulus fills the buffer with a counting pattern, provokes the dropped write, and then drains every entry. Each drained byte is compared with the expected sequence, so a lost byte that was somehow stored would show up in the data order, and not only in the count. A watermark of 200 is applied at levels 15 and 16 to tell clamping apart from plain truncation of the upper bits.

// File: rtl/thr_fifo_pkg.sv
package thr_fifo_pkg;

   // occupancy flags derived from the fill count
   typedef struct packed {
      logic full;
      logic not_empty;
      logic empty;
      logic not_full;
   } fifo_stat_t;

endpackage

// File: rtl/thr_fifo_store.sv
module thr_fifo_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] ent [DEPTH];

   // one register per slot, written only when addressed
   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == PTR_W'(e))) begin
            q <= wr_data;
         end
      end
      assign ent[e] = q;
   end

   assign rd_data = ent[rd_addr];

endmodule

// File: rtl/thr_fifo_ctrl.sv
module thr_fifo_ctrl #(
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [LVL_W-1:0] level,
   output logic             ovf,
   output logic             unf
);

   localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
   localparam bit               POW2     = ((1 << PTR_W) == DEPTH);

   logic             is_full, is_empty;
   logic             acc_push, acc_pop, bad_push, bad_pop;
   logic [PTR_W-1:0] wr_nx, rd_nx;

   assign is_full  = (level == LVL_FULL);
   assign is_empty = (level == '0);

   // legal and illegal traffic, all masked by flush
   assign acc_push = push && !flush && !is_full;
   assign acc_pop  = pop  && !flush && !is_empty;
   assign bad_push = push && !flush &&  is_full;
   assign bad_pop  = pop  && !flush &&  is_empty;

   assign wr_en = acc_push;

   // pointer advance: natural wrap for power-of-two depth, compare otherwise
   if (POW2) begin : g_wrap_nat
      assign wr_nx = wr_ptr + PTR_W'(1);
      assign rd_nx = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (acc_push) wr_ptr <= wr_nx;
         if (acc_pop)  rd_ptr <= rd_nx;
         level <= level + LVL_W'(acc_push) - LVL_W'(acc_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf <= 1'b0;
         unf <= 1'b0;
      end else begin
         ovf <= bad_push;
         unf <= bad_pop;
      end
   end

endmodule

// File: rtl/thr_fifo_flags.sv
module thr_fifo_flags
   import thr_fifo_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int THR_W  = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic [LVL_W-1:0] level,
   input  logic [THR_W-1:0] thr,
   output logic             rx_hit,
   output logic             tx_hit,
   output fifo_stat_t       stat
);

   localparam int               THR_MAX  = DEPTH - 1;
   localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

   logic [LVL_W-1:0] thr_eff;

   // clamp: anything above the top legal watermark acts as the top value
   if (THR_W > LVL_W) begin : g_thr_wide
      assign thr_eff = (thr > THR_W'(THR_MAX)) ? LVL_W'(THR_MAX) : thr[LVL_W-1:0];
   end else begin : g_thr_narrow
      logic [LVL_W-1:0] thr_ext;
      assign thr_ext = LVL_W'(thr);
      assign thr_eff = (thr_ext > LVL_W'(THR_MAX)) ? LVL_W'(THR_MAX) : thr_ext;
   end

   assign rx_hit = (level > thr_eff);
   assign tx_hit = (level <= thr_eff);

   assign stat.full      = (level == LVL_FULL);
   assign stat.not_full  = (level != LVL_FULL);
   assign stat.empty     = (level == '0);
   assign stat.not_empty = (level != '0);

endmodule

// File: rtl/thr_fifo.sv
module thr_fifo
   import thr_fifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int THR_W  = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data_o,
   input  logic              flush_i,
   input  logic [THR_W-1:0]  thr_i,
   output logic [LVL_W-1:0]  level_o,
   output logic              rx_thr_o,
   output logic              tx_thr_o,
   output logic              full_o,
   output logic              not_empty_o,
   output logic              empty_o,
   output logic              not_full_o,
   output logic              ovf_o,
   output logic              unf_o
);

   // elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("thr_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("thr_fifo: DATA_W must be at least 1");
   end
   if (THR_W < PTR_W) begin : g_bad_thr
      $error("thr_fifo: THR_W too narrow to address every watermark");
   end

   logic             wr_en;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [LVL_W-1:0] level;
   fifo_stat_t       stat;

   thr_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push_i),
      .pop    (pop_i),
      .flush  (flush_i),
      .wr_en  (wr_en),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .level  (level),
      .ovf    (ovf_o),
      .unf    (unf_o)
   );

   thr_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_ptr),
      .wr_data (push_data_i),
      .rd_addr (rd_ptr),
      .rd_data (pop_data_o)
   );

   thr_fifo_flags #(.DEPTH(DEPTH), .THR_W(THR_W)) u_flags (
      .level  (level),
      .thr    (thr_i),
      .rx_hit (rx_thr_o),
      .tx_hit (tx_thr_o),
      .stat   (stat)
   );

   assign level_o     = level;
   assign full_o      = stat.full;
   assign not_empty_o = stat.not_empty;
   assign empty_o     = stat.empty;
   assign not_full_o  = stat.not_full;

endmodule

// File: rtl/thr_fifo_chk.sv
module thr_fifo_chk #(
   parameter int DEPTH  = 16,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_i,
   input logic             pop_i,
   input logic             flush_i,
   input logic [LVL_W-1:0] level_o,
   input logic             full_o,
   input logic             not_empty_o,
   input logic             empty_o,
   input logic             not_full_o,
   input logic             ovf_o,
   input logic             unf_o,
   input logic             rx_thr_o
);

   a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= LVL_W'(DEPTH));

   a_r3_drop_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i && !pop_i && !flush_i) |=> (ovf_o && full_o));

   a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && pop_i && !push_i && !flush_i) |=> (unf_o && empty_o));

   a_r5_flag_pairs: assert property (@(posedge clk) disable iff (!rst_n)
      (not_full_o != full_o) && (not_empty_o != empty_o) && !(full_o && empty_o));

   a_r6_rx_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      rx_thr_o |-> not_empty_o);

   a_r9_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (empty_o && !ovf_o && !unf_o));

   a_r10_steady_level: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && not_empty_o && not_full_o && !flush_i) |=> $stable(level_o));

endmodule

bind thr_fifo thr_fifo_chk #(.DEPTH(DEPTH)) u_thr_fifo_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .flush_i     (flush_i),
   .level_o     (level_o),
   .full_o      (full_o),
   .not_empty_o (not_empty_o),
   .empty_o     (empty_o),
   .not_full_o  (not_full_o),
   .ovf_o       (ovf_o),
   .unf_o       (unf_o),
   .rx_thr_o    (rx_thr_o)
);

// File: tb/thr_fifo_bench.sv
module thr_fifo_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 1'b0;
   logic [7:0] push_data_i = 8'h00;
   logic       pop_i = 1'b0;
   logic [7:0] pop_data_o;
   logic       flush_i = 1'b0;
   logic [7:0] thr_i = 8'd0;
   logic [4:0] level_o;
   logic       rx_thr_o, tx_thr_o, full_o, not_empty_o, empty_o, not_full_o;
   logic       ovf_o, unf_o;

   int nchk = 0;
   int nerr = 0;

   always #2 clk = ~clk;

   thr_fifo u_thr_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
      .pop_i(pop_i), .pop_data_o(pop_data_o), .flush_i(flush_i), .thr_i(thr_i),
      .level_o(level_o), .rx_thr_o(rx_thr_o), .tx_thr_o(tx_thr_o),
      .full_o(full_o), .not_empty_o(not_empty_o), .empty_o(empty_o),
      .not_full_o(not_full_o), .ovf_o(ovf_o), .unf_o(unf_o)
   );

   // stimulus/expectation rows: push pop flush data level ovf unf head
   typedef struct packed {
      logic       push;
      logic       pop;
      logic       flush;
      logic [7:0] data;
      logic [4:0] lvl;
      logic       ovf;
      logic       unf;
      logic [7:0] head;
   } vec_t;

   localparam int NV = 12;
   localparam logic [25:0] VECS [NV] = '{
      {3'b010, 8'h00, 5'd0, 2'b01, 8'h00},  // R4 pop on empty
      {3'b100, 8'hA1, 5'd1, 2'b00, 8'hA1},
      {3'b100, 8'hB2, 5'd2, 2'b00, 8'hA1},
      {3'b110, 8'hC3, 5'd2, 2'b00, 8'hB2},  // R10 push+pop mid
      {3'b010, 8'h00, 5'd1, 2'b00, 8'hC3},
      {3'b110, 8'hD4, 5'd1, 2'b00, 8'hD4},  // R10 at level one
      {3'b010, 8'h00, 5'd0, 2'b00, 8'h00},
      {3'b110, 8'hE5, 5'd1, 2'b01, 8'hE5},  // R11 push+pop on empty
      {3'b101, 8'h66, 5'd0, 2'b00, 8'h00},  // R9 flush with push
      {3'b011, 8'h00, 5'd0, 2'b00, 8'h00},  // R9 flush with pop, no pulse
      {3'b100, 8'h77, 5'd1, 2'b00, 8'h77},
      {3'b100, 8'h88, 5'd2, 2'b00, 8'h77}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at a falling edge, pass one rising edge, return at the next falling edge
   task automatic step(input logic pu, input logic [7:0] d, input logic po, input logic fl);
      push_i = pu; push_data_i = d; pop_i = po; flush_i = fl;
      @(posedge clk);
      @(negedge clk);
      push_i = 1'b0; pop_i = 1'b0; flush_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=running expected=complete");
      finish_run();
   end

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      // reset state (R1, R5)
      chk("R1 reset level", 32'(level_o), 32'd0);
      chk("R5 reset flags", {28'd0, full_o, not_empty_o, empty_o, not_full_o}, 32'b0011);
      chk("R3 reset ovf", 32'(ovf_o), 32'd0);
      chk("R4 reset unf", 32'(unf_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int i = 0; i < NV; i++) begin
         v = vec_t'(VECS[i]);
         step(v.push, v.data, v.pop, v.flush);
         chk("R1 table level", 32'(level_o), 32'(v.lvl));
         chk("R3 table ovf", 32'(ovf_o), 32'(v.ovf));
         chk("R4 table unf", 32'(unf_o), 32'(v.unf));
         if (v.lvl != 0) chk("R2 table head", 32'(pop_data_o), 32'(v.head));
      end

      // reset again mid-run
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R1 re-reset level", 32'(level_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // fill with watermark 5, checking both threshold flags at each level
      thr_i = 8'd5;
      #1;
      chk("R6 rx at level 0", 32'(rx_thr_o), 32'd0);
      chk("R7 tx at level 0", 32'(tx_thr_o), 32'd1);
      for (int k = 0; k < 16; k++) begin
         step(1'b1, 8'(k), 1'b0, 1'b0);
         chk("R1 fill level", 32'(level_o), 32'(k + 1));
         chk("R6 rx watermark 5", 32'(rx_thr_o), 32'((k + 1) >= 6));
         chk("R7 tx watermark 5", 32'(tx_thr_o), 32'((k + 1) <= 5));
      end
      chk("R5 full flags", {28'd0, full_o, not_empty_o, empty_o, not_full_o}, 32'b1100);

      // watermark 200 acts as 15 (R8)
      thr_i = 8'd200;
      #1;
      chk("R8 rx at 16 with 200", 32'(rx_thr_o), 32'd1);
      chk("R8 tx at 16 with 200", 32'(tx_thr_o), 32'd0);

      // dropped write on full (R3)
      step(1'b1, 8'hEE, 1'b0, 1'b0);
      chk("R3 level after full push", 32'(level_o), 32'd16);
      chk("R3 ovf pulse", 32'(ovf_o), 32'd1);
      step(1'b0, 8'h00, 1'b0, 1'b0);
      chk("R3 ovf one cycle", 32'(ovf_o), 32'd0);

      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R1 level 15", 32'(level_o), 32'd15);
      chk("R8 rx at 15 with 200", 32'(rx_thr_o), 32'd0);
      chk("R8 tx at 15 with 200", 32'(tx_thr_o), 32'd1);
      chk("R5 not full at 15", {28'd0, full_o, not_empty_o, empty_o, not_full_o}, 32'b0101);

      step(1'b1, 8'h10, 1'b0, 1'b0);
      // push and pop together on full: push lost, pop proceeds (R3)
      step(1'b1, 8'hEF, 1'b1, 1'b0);
      chk("R3 full push+pop level", 32'(level_o), 32'd15);
      chk("R3 full push+pop ovf", 32'(ovf_o), 32'd1);

      // drain: expect 2..16 in order, no dropped bytes (R2)
      for (int k = 2; k <= 16; k++) begin
         chk("R2 drain order", 32'(pop_data_o), 32'(k));
         step(1'b0, 8'h00, 1'b1, 1'b0);
      end
      chk("R1 drained", 32'(level_o), 32'd0);
      chk("R4 no unf on last pop", 32'(unf_o), 32'd0);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R4 unf after empty pop", 32'(unf_o), 32'd1);
      chk("R4 level stays 0", 32'(level_o), 32'd0);

      // held flush (R9)
      for (int k = 0; k < 3; k++) step(1'b1, 8'(8'h30 + k), 1'b0, 1'b0);
      chk("R1 before flush", 32'(level_o), 32'd3);
      for (int k = 0; k < 3; k++) begin
         step(1'b1, 8'h99, 1'b1, 1'b1);
         chk("R9 flush level", 32'(level_o), 32'd0);
         chk("R9 flush no pulses", {30'd0, ovf_o, unf_o}, 32'd0);
      end
      step(1'b1, 8'h5A, 1'b0, 1'b0);
      chk("R9 after release level", 32'(level_o), 32'd1);
      chk("R9 after release head", 32'(pop_data_o), 32'h5A);

      finish_run();
   end

endmodule